// File: doc/BRIEF.md
# Dual-clock FIFO with retransmit

This block buffers a stream of 18-bit words between two unrelated clock domains. A producer writes on its own free-running clock and a consumer reads on another. The storage depth is a power-of-two parameter, and the expected settings run from 256 to 4096 words. The write and read positions cross between the domains as Gray-coded values. Each status flag is worked out in the domain that acts on it. All flags are active low. The write domain drives full, half-full and almost-full. The read domain drives empty and almost-empty.

The two almost thresholds are held in offset registers. They are loaded through the normal data input whenever a load strobe goes with a write strobe. The output bus is registered. An output-enable input either drives the bus or lets it float. A read made while the bus floats still uses up a word, so unwanted words can be thrown away. A retransmit strobe sends the read position back to where it stood after the last reset, and the stored stream can then be read again from its start.

Top module: `fifo18_rt`

## Requirements
- R1: On a write-clock edge where `wr_en_n` is 0, `ld_n` is 1 and the FIFO is not full, `din` is stored. Words come out in the order they were stored.
- R2: On a read-clock edge where `rd_en_n` is 0, `rt_n` is 1 and the FIFO is not empty, the next word is taken into the output register, and `dout` shows it after that edge. On every other edge the output register keeps its value.
- R3: While `oe_n` is 1, `dout` is released to high impedance. A read made in that state still takes its word, and the following read shows the word after it.
- R4: `empty_n` is 0 while the read domain sees no stored words. It goes low right after the read edge that takes the last word. After a write it goes high on the second read-clock edge that follows the write edge.
- R5: `full_n` goes to 0 right after the write edge that stores word number DEPTH. A write attempted while full is dropped, and no word is lost or added.
- R6: A read attempted while empty is ignored. `dout` keeps its value, and the next word stored is the next word read.
- R7: `half_n` is 0 while the write domain counts more than DEPTH/2 stored words.
- R8: `afull_n` is 0 while the write-domain count is at least DEPTH minus the almost-full offset. `aempty_n` is 0 while the read-domain count is at most the almost-empty offset. After reset both offsets take the parameter values AE_OFS and AF_OFS (8 by default).
- R9: A write-clock edge where both `ld_n` and `wr_en_n` are 0 stores no word. It loads `din[AW-1:0]` into an offset register instead, where AW is log2(DEPTH). The first load after reset sets the almost-empty offset, the next sets the almost-full offset, and the loads keep alternating in that order.
- R10: When `rt_n` is 0 on a read-clock edge, the read position returns to its value after reset, and the output register keeps its value. Retransmit wins over a read on the same edge. The next read returns the first word written since reset.
- R11: While `rst_n` is 0 on clock edges, everything is cleared: `empty_n`=0, `full_n`=1, `half_n`=1, `aempty_n`=0, `afull_n`=1, and the output register is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock, free running |
| rclk | input | 1 | Read clock, free running |
| rst_n | input | 1 | Synchronous reset, active low, held across edges of both clocks |
| wr_en_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Offset-load select, active low, acts together with wr_en_n |
| din | input | 18 | Write data, or offset value during a load |
| rd_en_n | input | 1 | Read strobe, active low |
| oe_n | input | 1 | Output enable, active low; high releases dout |
| rt_n | input | 1 | Retransmit strobe, active low |
| dout | output | 18 | Registered read data, tri-stated by oe_n |
| empty_n | output | 1 | Empty, active low (read domain) |
| full_n | output | 1 | Full, active low (write domain) |
| half_n | output | 1 | More than half full, active low (write domain) |
| aempty_n | output | 1 | Almost empty, active low (read domain) |
| afull_n | output | 1 | Almost full, active low (write domain) |

## Verification
Flags and data owned by the domain that made a change move on that same edge. The register outputs `dout`, `full_n`, `half_n` and `afull_n` after a write, and `empty_n` and `aempty_n` after a read, are therefore checked half a cycle after the edge that caused them. A flag that depends on the other domain's position waits for the two-flop synchroniser, so `empty_n` is checked low, low and then high at the first three falling edges after a write. The bench drives every input on a falling edge and samples on the next falling edge. It inserts three idle cycles wherever a crossed value matters, so that no check lands in the window where a synchroniser is still settling.

// File: rtl/fifo18_pkg.sv
// Shared helpers for the dual-clock FIFO.
// Assumes pointer widths never exceed 16 bits (depth up to 32K words).
package fifo18_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int WORD_W = 18;

    // Which offset register the next load writes.
    typedef enum logic {
        SEL_AEMPTY = 1'b0,
        SEL_AFULL  = 1'b1
    } ofs_sel_e;

    // Binary to reflected Gray code.
    function automatic logic [15:0] bin2gray(input logic [15:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [15:0] gray2bin(input logic [15:0] g);
        logic [15:0] b;
        b[15] = g[15];
        for (int i = 14; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/fifo18_sync.sv
// Two-flop synchroniser for a Gray-coded pointer.
// Assumes the source changes at most one bit per source clock, except on
// reset and retransmit, where the receiving side tolerates a settling gap.
module fifo18_sync #(
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] d,
    output logic [PW-1:0] q
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [PW-1:0] meta;

    // Capture the foreign pointer, then re-register it once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fifo18_store.sv
// Storage array: one write port on the write clock, one asynchronous read port.
// Assumes the read side registers the data it takes.
module fifo18_store #(
    parameter int W  = 18,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Store one word per write-clock edge when enabled.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the addressed word to the read side.
    assign rdata = mem[raddr];
endmodule

// File: rtl/fifo18_wr.sv
// Write-domain control: write pointer, offset registers and the full,
// half-full and almost-full flags.
// Assumes rgray_s is already synchronised into wclk. Offsets are expected to be
// loaded while the read domain is idle, because ae_ofs is used there unsynchronised.
module fifo18_wr
    import fifo18_pkg::*;
#(
    parameter int W      = 18,
    parameter int AW     = 8,
    parameter int AE_OFS = 8,
    parameter int AF_OFS = 8
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          ld_n,
    input  logic [W-1:0]  din,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] ae_ofs,
    output logic          full_n,
    output logic          half_n,
    output logic          afull_n
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wbin, wbin_nx, rbin_s, wcount;
    logic [AW-1:0] af_ofs;
    logic [15:0]   rb_wide, wg_wide;
    logic          is_full, do_wr, do_ld;
    ofs_sel_e      ld_sel;

    // Decode the read pointer and the occupancy seen from this side.
    always_comb begin
        rb_wide = gray2bin(16'(rgray_s));
        rbin_s  = rb_wide[PW-1:0];
        wcount  = wbin - rbin_s;
        is_full = (wcount == PW'(DEPTH));
        wbin_nx = wbin + PW'(1);
        wg_wide = bin2gray(16'(wbin_nx));
    end

    assign do_wr = !wr_en_n && ld_n && !is_full;
    assign do_ld = !wr_en_n && !ld_n;
    assign we    = do_wr;
    assign waddr = wbin[AW-1:0];

    // Advance the write pointer and its Gray copy on each accepted write.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (do_wr) begin
            wbin  <= wbin_nx;
            wgray <= wg_wide[PW-1:0];
        end
    end

    // Load offsets alternately, almost-empty first.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            ae_ofs <= AW'(AE_OFS);
            af_ofs <= AW'(AF_OFS);
            ld_sel <= SEL_AEMPTY;
        end else if (do_ld) begin
            if (ld_sel == SEL_AEMPTY) begin
                ae_ofs <= din[AW-1:0];
                ld_sel <= SEL_AFULL;
            end else begin
                af_ofs <= din[AW-1:0];
                ld_sel <= SEL_AEMPTY;
            end
        end
    end

    // Write-domain status flags, active low.
    assign full_n  = !is_full;
    assign half_n  = !(wcount > PW'(DEPTH / 2));
    assign afull_n = !(wcount >= (PW'(DEPTH) - {1'b0, af_ofs}));

    // R1: an accepted write moves the pointer by exactly one
    a_r1_wptr_step: assert property (@(posedge wclk) disable iff (!rst_n)
        (!wr_en_n && ld_n && full_n) |=> (wbin == $past(wbin) + PW'(1)));

    // R5: a write while full leaves the pointer alone
    a_r5_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && !wr_en_n) |=> $stable(wbin));

    // R9: an offset load stores no word
    a_r9_ld_no_store: assert property (@(posedge wclk) disable iff (!rst_n)
        (!wr_en_n && !ld_n) |=> $stable(wbin));

    // R7: full implies more than half full
    a_r7_full_half: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n) |-> (!half_n));
endmodule

// File: rtl/fifo18_rd.sv
// Read-domain control: read pointer, output register, retransmit and the
// empty and almost-empty flags.
// Assumes wgray_s is already synchronised into rclk. Retransmit is only
// meaningful while no more than DEPTH words have been written since reset.
module fifo18_rd
    import fifo18_pkg::*;
#(
    parameter int W  = 18,
    parameter int AW = 8
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_en_n,
    input  logic          rt_n,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] ae_ofs,
    input  logic [W-1:0]  rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [W-1:0]  q,
    output logic          empty_n,
    output logic          aempty_n
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PW = AW + 1;

    logic [PW-1:0] rbin, rbin_nx, wbin_s, rcount;
    logic [15:0]   wb_wide, rg_wide;
    logic          is_empty, do_rd;

    // Decode the write pointer and the occupancy seen from this side.
    always_comb begin
        wb_wide  = gray2bin(16'(wgray_s));
        wbin_s   = wb_wide[PW-1:0];
        rcount   = wbin_s - rbin;
        is_empty = (rcount == '0);
        rbin_nx  = rbin + PW'(1);
        rg_wide  = bin2gray(16'(rbin_nx));
    end

    assign do_rd = !rd_en_n && rt_n && !is_empty;
    assign raddr = rbin[AW-1:0];

    // Rewind on retransmit, otherwise take one word per accepted read.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            q     <= '0;
        end else if (!rt_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (do_rd) begin
            rbin  <= rbin_nx;
            rgray <= rg_wide[PW-1:0];
            q     <= rdata;
        end
    end

    // Read-domain status flags, active low.
    assign empty_n  = !is_empty;
    assign aempty_n = !(rcount <= {1'b0, ae_ofs});

    // R6: a read while empty changes neither pointer nor output
    a_r6_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
        (!empty_n && !rd_en_n && rt_n) |=> ($stable(rbin) && $stable(q)));

    // R10: retransmit rewinds and holds the output word
    a_r10_rewind: assert property (@(posedge rclk) disable iff (!rst_n)
        (!rt_n) |=> ((rbin == '0) && $stable(q)));

    // R2: without a read strobe the output register holds
    a_r2_q_hold: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en_n) |=> $stable(q));

    // R4: empty implies almost empty
    a_r4_empty_aempty: assert property (@(posedge rclk) disable iff (!rst_n)
        (!empty_n) |-> (!aempty_n));
endmodule

// File: rtl/fifo18_rt.sv
// Dual-clock 18-bit FIFO with loadable almost thresholds, output-enable
// gated reads and retransmit.
// Assumes DEPTH is a power of two, at least 16, and rst_n spans edges of both clocks.
module fifo18_rt #(
    parameter int DEPTH  = 256,
    parameter int AE_OFS = 8,
    parameter int AF_OFS = 8
) (
    input  logic        wclk,
    input  logic        rclk,
    input  logic        rst_n,
    input  logic        wr_en_n,
    input  logic        ld_n,
    input  logic [17:0] din,
    input  logic        rd_en_n,
    input  logic        oe_n,
    input  logic        rt_n,
    output wire  [17:0] dout,
    output logic        empty_n,
    output logic        full_n,
    output logic        half_n,
    output logic        aempty_n,
    output logic        afull_n
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W  = fifo18_pkg::WORD_W;
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          we;
    logic [AW-1:0] waddr, raddr, ae_ofs;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [W-1:0]  rdata, q;

    fifo18_wr #(.W(W), .AW(AW), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) u_wr (
        .wclk    (wclk),
        .rst_n   (rst_n),
        .wr_en_n (wr_en_n),
        .ld_n    (ld_n),
        .din     (din),
        .rgray_s (rgray_s),
        .we      (we),
        .waddr   (waddr),
        .wgray   (wgray),
        .ae_ofs  (ae_ofs),
        .full_n  (full_n),
        .half_n  (half_n),
        .afull_n (afull_n)
    );

    fifo18_store #(.W(W), .AW(AW)) u_store (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    fifo18_sync #(.PW(PW)) u_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    fifo18_sync #(.PW(PW)) u_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    fifo18_rd #(.W(W), .AW(AW)) u_rd (
        .rclk     (rclk),
        .rst_n    (rst_n),
        .rd_en_n  (rd_en_n),
        .rt_n     (rt_n),
        .wgray_s  (wgray_s),
        .ae_ofs   (ae_ofs),
        .rdata    (rdata),
        .raddr    (raddr),
        .rgray    (rgray),
        .q        (q),
        .empty_n  (empty_n),
        .aempty_n (aempty_n)
    );

    // Drive the bus only while output enable is asserted.
    assign dout = oe_n ? {W{1'bz}} : q;
endmodule

// File: tb/test_fifo18_rt.sv
// Bench for fifo18_rt: both clocks share one 200 MHz source, so crossing
// latencies are fixed. A released bus reads as all ones through tri1.
module test_fifo18_rt;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    logic rst_n = 1'b0, wr_en_n = 1'b1, ld_n = 1'b1, rd_en_n = 1'b1;
    logic oe_n = 1'b0, rt_n = 1'b1;
    logic [17:0] din = '0;
    tri1  [17:0] dout;
    logic empty_n, full_n, half_n, aempty_n, afull_n;
    int   n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    localparam logic [17:0] FLOAT = 18'h3FFFF;

    // Table: bit 18 is oe_n during the read, bits 17:0 the word written.
    localparam logic [18:0] VEC [8] = '{
        19'h01234, 19'h4ABCD, 19'h00F0F, 19'h43C3C,
        19'h40001, 19'h15555, 19'h2AAAA, 19'h0FFFE
    };

    fifo18_rt i_fifo18_rt (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .ld_n(ld_n),
        .din(din), .rd_en_n(rd_en_n), .oe_n(oe_n), .rt_n(rt_n), .dout(dout),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
        .aempty_n(aempty_n), .afull_n(afull_n)
    );

    always #2.5 clk = ~clk;

    task automatic chk1(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chkw(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic put(input logic [17:0] w);
        din = w;
        wr_en_n = 1'b0;
        @(negedge clk);
        wr_en_n = 1'b1;
    endtask

    task automatic take_chk(input string req, input logic oe, input logic [17:0] exp);
        oe_n = oe;
        rd_en_n = 1'b0;
        @(negedge clk);
        rd_en_n = 1'b1;
        chkw(req, dout, exp);
        oe_n = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en_n = 1'b1; ld_n = 1'b1;
        rd_en_n = 1'b1; rt_n = 1'b1; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R11: reset state
        chk1("R11 empty_n", empty_n, 1'b0);
        chk1("R11 full_n", full_n, 1'b1);
        chk1("R11 half_n", half_n, 1'b1);
        chk1("R11 aempty_n", aempty_n, 1'b0);
        chk1("R11 afull_n", afull_n, 1'b1);
        chkw("R11 dout", dout, 18'h00000);

        // R4: empty_n rises on the second read edge after a write
        put(18'h00011);
        chk1("R4 latency 0", empty_n, 1'b0);
        tick();
        chk1("R4 latency 1", empty_n, 1'b0);
        tick();
        chk1("R4 latency 2", empty_n, 1'b1);
        take_chk("R2 first word", 1'b0, 18'h00011);
        chk1("R4 empty after last read", empty_n, 1'b0);
        // R6: read while empty ignored
        take_chk("R6 hold on empty read", 1'b0, 18'h00011);
        put(18'h00022);
        settle();
        take_chk("R6 next word after empty read", 1'b0, 18'h00022);

        // R1 R3: table of words, some read with the bus released
        do_reset();
        for (int k = 0; k < 8; k++) put(VEC[k][17:0]);
        settle();
        for (int k = 0; k < 8; k++) begin
            take_chk("R1 R3 table", VEC[k][18], VEC[k][18] ? FLOAT : VEC[k][17:0]);
        end
        chk1("R3 table drained", empty_n, 1'b0);

        // R5 R7 R8: fill to full, drain in order
        do_reset();
        for (int i = 0; i < 256; i++) begin
            put(18'(i + 1));
            if (i + 1 == 128) chk1("R7 half at 128", half_n, 1'b1);
            if (i + 1 == 129) chk1("R7 half at 129", half_n, 1'b0);
            if (i + 1 == 247) chk1("R8 afull at 247", afull_n, 1'b1);
            if (i + 1 == 248) chk1("R8 afull at 248", afull_n, 1'b0);
            if (i + 1 == 255) chk1("R5 full at 255", full_n, 1'b1);
            if (i + 1 == 256) chk1("R5 full at 256", full_n, 1'b0);
        end
        put(18'h2AAAA);
        chk1("R5 full after dropped write", full_n, 1'b0);
        settle();
        chk1("R8 aempty when full", aempty_n, 1'b1);
        for (int i = 0; i < 256; i++) begin
            take_chk("R1 R5 drain order", 1'b0, 18'(i + 1));
            if (i + 1 == 247) chk1("R8 aempty at 9 left", aempty_n, 1'b1);
            if (i + 1 == 248) chk1("R8 aempty at 8 left", aempty_n, 1'b0);
        end
        chk1("R5 empty after drain", empty_n, 1'b0);
        settle();
        take_chk("R5 dropped word absent", 1'b0, 18'h00100);

        // R9: load ae=4 then af=6
        do_reset();
        ld_n = 1'b0;
        put(18'h00004);
        put(18'h00006);
        ld_n = 1'b1;
        settle();
        chk1("R9 load stores nothing", empty_n, 1'b0);
        for (int i = 0; i < 4; i++) put(18'(i + 1));
        settle();
        chk1("R9 aempty at 4 with ofs 4", aempty_n, 1'b0);
        put(18'h00005);
        settle();
        chk1("R9 aempty at 5 with ofs 4", aempty_n, 1'b1);
        for (int i = 6; i <= 249; i++) put(18'(i));
        chk1("R9 afull at 249 with ofs 6", afull_n, 1'b1);
        put(18'h000FA);
        chk1("R9 afull at 250 with ofs 6", afull_n, 1'b0);

        // R9: reset restores sequence and defaults
        do_reset();
        ld_n = 1'b0;
        put(18'h00003);
        ld_n = 1'b1;
        for (int i = 0; i < 3; i++) put(18'(i + 1));
        settle();
        chk1("R9 first load after reset is aempty", aempty_n, 1'b0);
        put(18'h00004);
        settle();
        chk1("R9 aempty at 4 with ofs 3", aempty_n, 1'b1);
        for (int i = 5; i <= 247; i++) put(18'(i));
        chk1("R9 default afull at 247", afull_n, 1'b1);
        put(18'h000F8);
        chk1("R9 default afull at 248", afull_n, 1'b0);

        // R10: retransmit
        do_reset();
        for (int i = 0; i < 5; i++) put(18'h0A000 + 18'(i));
        settle();
        take_chk("R10 pre A", 1'b0, 18'h0A000);
        take_chk("R10 pre B", 1'b0, 18'h0A001);
        take_chk("R10 pre C", 1'b0, 18'h0A002);
        rt_n = 1'b0;
        rd_en_n = 1'b0;
        tick();
        rt_n = 1'b1;
        rd_en_n = 1'b1;
        chkw("R10 output held on rewind", dout, 18'h0A002);
        for (int i = 0; i < 5; i++) take_chk("R10 reread", 1'b0, 18'h0A000 + 18'(i));
        chk1("R10 empty after reread", empty_n, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule